// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the operand store of a small 32-bit RISC core. It holds twenty-five physical 32-bit entries. At any moment sixteen architectural registers, numbered 0 to 15, are visible through them. Register 15 is the program counter. The processor mode is an input. In privileged modes some architectural numbers are steered to private physical copies, so an interrupt handler can use its own stack and link registers without saving the user ones first.

Two combinational read ports supply the ALU operands. One clocked write port takes the ALU result. The program counter sits in its own register and has a dedicated read output and a dedicated write input next to the general ports. Reads settle within the cycle and writes land on the rising clock edge. This models the read-early / write-late split of a two-phase core: a value written in one cycle is seen by reads in the following cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset the program counter is zero, both on `pc_rd_data` and on a general read of register 15; reset touches no other entry.
- R2: A general write becomes visible on the read ports from the cycle after its clock edge; in the cycle of the write the read ports still return the old value.
- R3: In user mode (`mode` = 2'b00) registers 0 to 14 are fifteen independent entries, each holding what was last written to it.
- R4: In fast-interrupt mode (`mode` = 2'b01) registers 10 to 14 reach five private entries, so writes there leave the user copies unchanged; registers 0 to 9 stay shared with user mode.
- R5: In interrupt mode (`mode` = 2'b10) registers 13 and 14 reach two private entries; register 12 and below stay shared with user mode.
- R6: In supervisor mode (`mode` = 2'b11) registers 13 and 14 reach two private entries that are distinct from both the interrupt-mode and the user copies.
- R7: A write on the dedicated port (`pc_wr_en` high) updates the program counter at the next edge, and a general-port read of register 15 returns the same value as `pc_rd_data`, in every mode.
- R8: When the general port writes register 15 and the dedicated port writes in the same cycle, the general-port data is the value stored.
- R9: With `wr_en` low the general port changes no entry, and with both `pc_wr_en` low and no general write to register 15 the program counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Processor mode: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor |
| rd_a_idx | input | 4 | Architectural index for operand port A |
| rd_a_data | output | 32 | Operand port A data (combinational) |
| rd_b_idx | input | 4 | Architectural index for operand port B |
| rd_b_data | output | 32 | Operand port B data (combinational) |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Architectural index for the general write |
| wr_data | input | 32 | General write data |
| pc_rd_data | output | 32 | Current program counter |
| pc_wr_en | input | 1 | Dedicated program-counter write enable |
| pc_wr_data | input | 32 | Dedicated program-counter write data |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and the full set of twenty-four general entries plus the program counter. This means every banked copy in each of the three privileged modes exists and can be told apart from its user-mode twin. The test data carry distinct patterns in both the upper and the lower halfword, so a wrong physical mapping shows up as a value that belongs to another entry. A swapped bank base or a missing override shows up the same way.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  localparam int ARCH_REGS     = 16;
  localparam int AIDX_W        = $clog2(ARCH_REGS);
  localparam int PC_IDX        = ARCH_REGS - 1;
  // general entries: user 0..14, fast bank 5, irq bank 2, svc bank 2
  localparam int FAST_FIRST    = 10;
  localparam int FAST_COUNT    = 5;
  localparam int PRIV_FIRST    = 13;
  localparam int PRIV_COUNT    = 2;
  localparam int USER_ENTRIES  = ARCH_REGS - 1;
  localparam int FAST_BASE     = USER_ENTRIES;
  localparam int IRQ_BASE      = FAST_BASE + FAST_COUNT;
  localparam int SVC_BASE      = IRQ_BASE + PRIV_COUNT;
  localparam int STORE_ENTRIES = SVC_BASE + PRIV_COUNT;
  localparam int PIDX_W        = $clog2(STORE_ENTRIES);

endpackage

// File: rtl/bankrf_rst_sync.sv
module bankrf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [AIDX_W-1:0] arch_idx,
  output logic [PIDX_W-1:0] phys_idx,
  output logic              is_pc
);

  logic in_fast;
  logic in_priv;

  always_comb begin
    is_pc   = (arch_idx == AIDX_W'(PC_IDX));
    in_fast = (arch_idx >= AIDX_W'(FAST_FIRST)) && (arch_idx < AIDX_W'(PC_IDX));
    in_priv = (arch_idx >= AIDX_W'(PRIV_FIRST)) && (arch_idx < AIDX_W'(PC_IDX));
    phys_idx = PIDX_W'(arch_idx);
    case (cpu_mode_e'(mode))
      MODE_FIQ: if (in_fast)
        phys_idx = PIDX_W'(FAST_BASE) + PIDX_W'(arch_idx - AIDX_W'(FAST_FIRST));
      MODE_IRQ: if (in_priv)
        phys_idx = PIDX_W'(IRQ_BASE) + PIDX_W'(arch_idx - AIDX_W'(PRIV_FIRST));
      MODE_SVC: if (in_priv)
        phys_idx = PIDX_W'(SVC_BASE) + PIDX_W'(arch_idx - AIDX_W'(PRIV_FIRST));
      default: ;
    endcase
  end

endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 24,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] cell_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    logic cell_ce;
    assign cell_ce = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (cell_ce) cell_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_a_idx == IDX_W'(i)) rd_a_data = cell_q[i];
      if (rd_b_idx == IDX_W'(i)) rd_b_data = cell_q[i];
    end
  end

endmodule

// File: rtl/bankrf_pc.sv
module bankrf_pc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_wr,
  input  logic [DATA_W-1:0] gen_data,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_data,
  output logic [DATA_W-1:0] pc_q
);

  logic              pc_ce;
  logic [DATA_W-1:0] pc_d;

  always_comb begin
    pc_ce = gen_wr || port_wr;
    pc_d  = gen_wr ? gen_data : port_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_ce) pc_q <= pc_d;
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pc_rd_data,
  input  logic              pc_wr_en,
  input  logic [DATA_W-1:0] pc_wr_data
);

  logic              rst_n_sync;
  logic [PIDX_W-1:0] a_phys, b_phys, w_phys;
  logic              a_pc, b_pc, w_pc;
  logic [DATA_W-1:0] a_store, b_store;
  logic [DATA_W-1:0] pc_q;

  bankrf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  bankrf_map u_map_a (.mode(mode), .arch_idx(rd_a_idx), .phys_idx(a_phys), .is_pc(a_pc));
  bankrf_map u_map_b (.mode(mode), .arch_idx(rd_b_idx), .phys_idx(b_phys), .is_pc(b_pc));
  bankrf_map u_map_w (.mode(mode), .arch_idx(wr_idx),   .phys_idx(w_phys), .is_pc(w_pc));

  bankrf_store #(.DATA_W(DATA_W), .ENTRIES(STORE_ENTRIES), .IDX_W(PIDX_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_en && !w_pc),
    .wr_idx   (w_phys),
    .wr_data  (wr_data),
    .rd_a_idx (a_phys),
    .rd_b_idx (b_phys),
    .rd_a_data(a_store),
    .rd_b_data(b_store)
  );

  bankrf_pc #(.DATA_W(DATA_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .gen_wr   (wr_en && w_pc),
    .gen_data (wr_data),
    .port_wr  (pc_wr_en),
    .port_data(pc_wr_data),
    .pc_q     (pc_q)
  );

  assign rd_a_data  = a_pc ? pc_q : a_store;
  assign rd_b_data  = b_pc ? pc_q : b_store;
  assign pc_rd_data = pc_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pc_rd_data,
  input logic              pc_wr_en,
  input logic [DATA_W-1:0] pc_wr_data
);

  logic gen_pc_wr;
  assign gen_pc_wr = wr_en && (wr_idx == 4'd15);

  p_pc_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> pc_rd_data == '0);

  p_port_a_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == pc_rd_data));

  p_port_b_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'd15) |-> (rd_b_data == pc_rd_data));

  p_pc_port_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_en && !gen_pc_wr) |=> (pc_rd_data == $past(pc_wr_data)));

  p_gen_pc_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_pc_wr |=> (pc_rd_data == $past(wr_data)));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr_en && !gen_pc_wr) |=> $stable(pc_rd_data));

  p_wr_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_a_idx == $past(wr_idx) && mode == $past(mode))
               ? (rd_a_data == $past(wr_data)) : 1'b1));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

  typedef struct {
    int          sel;   // 0 port A, 1 port B, 2 pc output
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_rd_data, pc_wr_data;
  logic        wr_en, pc_wr_en;

  int    n_vec  = 0;
  int    n_fail = 0;
  item_t sb_q[$];
  event  sample_ev;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_rd_data(pc_rd_data), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data)
  );

  // monitor: pops the oldest expected item and compares
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = (it.sel == 0) ? rd_a_data : (it.sel == 1) ? rd_b_data : pc_rd_data;
        n_vec++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  // driver tasks
  task automatic push(input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    -> sample_ev;
  endtask

  task automatic chk(input int sel, input logic [3:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    if (sel == 0) rd_a_idx = idx;
    else if (sel == 1) rd_b_idx = idx;
    push(sel, exp, req);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; rd_a_idx = '0; rd_b_idx = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; pc_wr_en = 1'b0; pc_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset value of the program counter
    chk(2, 4'd0, 32'h0, "R1 pc output");
    chk(0, 4'd15, 32'h0, "R1 general read of r15");

    // R3: fifteen independent user entries
    for (int i = 0; i < 15; i++) wr(4'(i), 32'hA5C0_1000 + i);
    for (int i = 0; i < 15; i++) chk(1, 4'(i), 32'hA5C0_1000 + i, "R3 user entry");

    // R2: old value during the write cycle, new value afterwards
    @(negedge clk);
    rd_a_idx = 4'd3; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333_CAFE;
    push(0, 32'hA5C0_1003, "R2 old value in write cycle");
    @(negedge clk);
    wr_en = 1'b0;
    push(0, 32'h3333_CAFE, "R2 new value next cycle");

    // R4: fast-interrupt bank
    set_mode(2'b01);
    for (int i = 10; i < 15; i++) wr(4'(i), 32'hF1F0_0000 + i);
    chk(0, 4'd10, 32'hF1F0_000A, "R4 fast bank r10");
    chk(1, 4'd14, 32'hF1F0_000E, "R4 fast bank r14");
    chk(0, 4'd8,  32'hA5C0_1008, "R4 r8 shared");
    wr(4'd8, 32'h0088_8800);
    set_mode(2'b00);
    chk(0, 4'd10, 32'hA5C0_100A, "R4 user r10 untouched");
    chk(1, 4'd14, 32'hA5C0_100E, "R4 user r14 untouched");
    chk(0, 4'd8,  32'h0088_8800, "R4 shared r8 written in fast mode");

    // R5: interrupt bank
    set_mode(2'b10);
    wr(4'd13, 32'h1E00_0D0D);
    wr(4'd14, 32'h1E00_0E0E);
    chk(0, 4'd12, 32'hA5C0_100C, "R5 r12 shared");
    chk(1, 4'd13, 32'h1E00_0D0D, "R5 irq r13");
    chk(0, 4'd11, 32'hA5C0_100B, "R5 r11 shared");

    // R6: supervisor bank distinct from irq and user
    set_mode(2'b11);
    wr(4'd13, 32'h5C00_D00D);
    wr(4'd14, 32'h5C00_E00E);
    chk(0, 4'd13, 32'h5C00_D00D, "R6 svc r13");
    set_mode(2'b10);
    chk(0, 4'd13, 32'h1E00_0D0D, "R6 irq r13 kept");
    chk(1, 4'd14, 32'h1E00_0E0E, "R6 irq r14 kept");
    set_mode(2'b00);
    chk(0, 4'd13, 32'hA5C0_100D, "R6 user r13 kept");
    set_mode(2'b11);
    chk(1, 4'd14, 32'h5C00_E00E, "R6 svc r14");

    // R7: dedicated port write and general read of r15
    @(negedge clk);
    pc_wr_en = 1'b1; pc_wr_data = 32'h0000_0040;
    @(negedge clk);
    pc_wr_en = 1'b0;
    chk(2, 4'd0,  32'h0000_0040, "R7 pc output after port write");
    chk(0, 4'd15, 32'h0000_0040, "R7 r15 via port A in svc");
    set_mode(2'b01);
    chk(1, 4'd15, 32'h0000_0040, "R7 r15 via port B in fast mode");

    // R8: general write to r15 beats the dedicated port
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_0123;
    pc_wr_en = 1'b1; pc_wr_data = 32'h0000_0456;
    @(negedge clk);
    wr_en = 1'b0; pc_wr_en = 1'b0;
    chk(2, 4'd0, 32'h0000_0123, "R8 general port priority");

    // R9: disabled writes leave state alone
    set_mode(2'b00);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd5; wr_data = 32'hDEAD_BEEF;
    pc_wr_en = 1'b0; pc_wr_data = 32'hBAD0_BAD0;
    @(negedge clk);
    chk(0, 4'd5, 32'hA5C0_1005, "R9 r5 unchanged with wr_en low");
    chk(2, 4'd0, 32'h0000_0123, "R9 pc held");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule